// File: doc/BRIEF.md
# Product-Term Sum Cell With Cascade Chain

This block is the combinational logic core of one cell in a programmable sum-of-products fabric. It reads a vector of input signals. Each of five AND terms can take any input signal in true or complemented form. A routing mask sends each term either into the cell's local OR sum or out to a dedicated control line. On a control line the term can drive a clock enable, a reset or an output enable in the register stage that follows. The register stage is not part of this block.

The local OR sum also absorbs a cascade input from the neighbouring cell. The combined sum leaves the cell on a cascade output, so a chain of cells can build one wide sum. A final XOR stage sets the polarity of that sum. Its second operand is either a fixed level or one selected product term, which serves compare and arithmetic uses. Each cell also drives an inverted copy of one chosen term onto a shared regional line. All configuration arrives as static bit vectors on the ports.

Top module: `ptsum_cell`

## Requirements
- R1: Each input signal has a 2-bit literal code in every term, at bits [(t*NUM_IN+i)*2 +: 2] of `termCfg`. The codes are: 2'b00 ignores the signal, 2'b01 includes the signal true, 2'b10 includes it complemented, and 2'b11 includes both forms, which forces the term to 0. A term is the AND of its included literals.
- R2: A term whose literal codes are all 2'b00 evaluates to 1.
- R3: When `routeCfg[t]`=1, term t goes to `ctrlOut[t]` and contributes 0 to the OR sum. When `routeCfg[t]`=0, `ctrlOut[t]` is 0 and the term enters the sum.
- R4: `casOut` is the OR of every sum-routed term together with `casIn`. With `casIn`=0 and all five terms routed to the sum, the cell forms a five-term sum of products.
- R5: When `xorMode`=2'b00, `cellOut` equals `casOut`. When `xorMode`=2'b01, `cellOut` is the inverse of `casOut`.
- R6: When `xorMode`=2'b10, `cellOut` is `casOut` XOR the raw value of term `xorIdx`, whatever that term's routing. An `xorIdx` of 5 or more counts as a 0 operand. `xorMode`=2'b11 behaves as 2'b00.
- R7: `foldOut` is the inverse of term `foldIdx`. When `foldIdx` is 5 or more, `foldOut` is 1.
- R8: When `casIn`=1, `casOut` is 1 whatever the terms are, so a chained sum passes through the cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sigIn | input | NUM_IN | Input signals seen by every term |
| termCfg | input | 5*NUM_IN*2 | Literal codes for every term and signal |
| routeCfg | input | 5 | Per term: 1 sends it to the control line, 0 sends it to the sum |
| xorMode | input | 2 | XOR operand select: 0 constant, 1 constant high, 2 term, 3 constant low |
| xorIdx | input | 3 | Term used as the XOR operand |
| foldIdx | input | 3 | Term whose inverse drives the regional line |
| casIn | input | 1 | Sum arriving from the neighbouring cell |
| casOut | output | 1 | Combined sum before the XOR, for the next cell |
| cellOut | output | 1 | Sum after the polarity or XOR stage |
| ctrlOut | output | 5 | Terms routed to control uses |
| foldOut | output | 1 | Inverted chosen term for the regional line |

## Verification
The bench targets the both-literals code. A design that treated that code as "ignore" would hold terms at 1 that should be 0. It targets empty terms: a design that gave an empty AND the value 0 would lose constant-true terms. It checks control-routed terms that are also asserted. A leaky routing mux would let such a term raise the sum. It drives out-of-range XOR and fold indices. A design that wrapped or truncated those indices would pick up a real term and flip `cellOut` or `foldOut`. It also forces `casIn` high while all local terms are zero. A broken chain there would drop `casOut`.

// File: rtl/ptsum_pkg.sv
package ptsum_pkg;
  localparam int PT_COUNT = 5;
  localparam int PT_IDX_W = 3;

  typedef enum logic [1:0] {
    XOR_ZERO = 2'b00,
    XOR_ONE  = 2'b01,
    XOR_TERM = 2'b10,
    XOR_RSVD = 2'b11
  } xorMode_e;

  // strobes from the decode logic to the term datapath
  typedef struct packed {
    logic [PT_COUNT-1:0] sumEn;
    logic [PT_COUNT-1:0] ctrlEn;
    logic [PT_COUNT-1:0] xorPick;
    logic [PT_COUNT-1:0] foldPick;
    logic                xorConstHi;
    logic                xorUseTerm;
  } cellStrobes_t;
endpackage

// File: rtl/ptsum_ctrl.sv
module ptsum_ctrl
  import ptsum_pkg::*;
(
  input  logic [PT_COUNT-1:0] routeCfg,
  input  logic [1:0]          xorMode,
  input  logic [PT_IDX_W-1:0] xorIdx,
  input  logic [PT_IDX_W-1:0] foldIdx,
  output cellStrobes_t        strobes
);
  xorMode_e modeDec;

  always_comb begin
    modeDec = xorMode_e'(xorMode);
    strobes.sumEn  = ~routeCfg;
    strobes.ctrlEn = routeCfg;
    strobes.xorConstHi = (modeDec == XOR_ONE);
    strobes.xorUseTerm = (modeDec == XOR_TERM);
  end

  genvar g;
  generate
    for (g = 0; g < PT_COUNT; g++) begin : gPick
      assign strobes.xorPick[g]  = (xorIdx  == PT_IDX_W'(g));
      assign strobes.foldPick[g] = (foldIdx == PT_IDX_W'(g));
    end
  endgenerate
endmodule

// File: rtl/ptsum_datapath.sv
module ptsum_datapath
  import ptsum_pkg::*;
#(
  parameter int NUM_IN = 8,
  localparam int CFG_W = PT_COUNT * NUM_IN * 2
) (
  input  logic [NUM_IN-1:0]   sigIn,
  input  logic [CFG_W-1:0]    termCfg,
  input  cellStrobes_t        strobes,
  input  logic                casIn,
  output logic                casOut,
  output logic                cellOut,
  output logic [PT_COUNT-1:0] ctrlOut,
  output logic                foldOut
);
  logic [PT_COUNT-1:0] termVal;
  logic xorOperand;

  genvar t;
  generate
    for (t = 0; t < PT_COUNT; t++) begin : gTerm
      logic [NUM_IN-1:0] litOk;
      genvar i;
      for (i = 0; i < NUM_IN; i++) begin : gLit
        logic [1:0] code;
        assign code = termCfg[(t*NUM_IN+i)*2 +: 2];
        assign litOk[i] = (~code[0] | sigIn[i]) & (~code[1] | ~sigIn[i]);
      end
      assign termVal[t] = &litOk;
    end
  endgenerate

  always_comb begin
    casOut = casIn | (|(termVal & strobes.sumEn));
    ctrlOut = termVal & strobes.ctrlEn;
    xorOperand = strobes.xorConstHi |
                 (strobes.xorUseTerm & (|(termVal & strobes.xorPick)));
    cellOut = casOut ^ xorOperand;
    foldOut = ~(|(termVal & strobes.foldPick));
  end
endmodule

// File: rtl/ptsum_cell.sv
module ptsum_cell
  import ptsum_pkg::*;
#(
  parameter int NUM_IN = 8,
  localparam int CFG_W = PT_COUNT * NUM_IN * 2
) (
  input  logic [NUM_IN-1:0]   sigIn,
  input  logic [CFG_W-1:0]    termCfg,
  input  logic [PT_COUNT-1:0] routeCfg,
  input  logic [1:0]          xorMode,
  input  logic [PT_IDX_W-1:0] xorIdx,
  input  logic [PT_IDX_W-1:0] foldIdx,
  input  logic                casIn,
  output logic                casOut,
  output logic                cellOut,
  output logic [PT_COUNT-1:0] ctrlOut,
  output logic                foldOut
);
  cellStrobes_t strobes;

  ptsum_ctrl u_ctrl (
    .routeCfg(routeCfg), .xorMode(xorMode), .xorIdx(xorIdx),
    .foldIdx(foldIdx), .strobes(strobes)
  );

  ptsum_datapath #(.NUM_IN(NUM_IN)) u_dp (
    .sigIn(sigIn), .termCfg(termCfg), .strobes(strobes), .casIn(casIn),
    .casOut(casOut), .cellOut(cellOut), .ctrlOut(ctrlOut), .foldOut(foldOut)
  );
endmodule

// File: rtl/ptsum_cell_chk.sv
module ptsum_cell_chk
  import ptsum_pkg::*;
(
  input logic [PT_COUNT-1:0] routeCfg,
  input logic [1:0]          xorMode,
  input logic [PT_IDX_W-1:0] xorIdx,
  input logic [PT_IDX_W-1:0] foldIdx,
  input logic                casIn,
  input logic                casOut,
  input logic                cellOut,
  input logic [PT_COUNT-1:0] ctrlOut,
  input logic                foldOut
);
  always_comb begin
    AST_CTRL_ONLY_ROUTED: assert ((ctrlOut & ~routeCfg) == '0); // R3
    AST_CHAIN_PASSES: assert (!casIn || casOut); // R8
    AST_POLARITY_INV: assert (xorMode != 2'b01 || cellOut == !casOut); // R5
    AST_POLARITY_KEEP: assert (xorMode != 2'b00 || cellOut == casOut); // R5
    AST_RSVD_AS_ZERO: assert (xorMode != 2'b11 || cellOut == casOut); // R6
    AST_XOR_IDX_OOR: assert (!(xorMode == 2'b10 && xorIdx >= PT_IDX_W'(PT_COUNT)) || cellOut == casOut); // R6
    AST_FOLD_IDX_OOR: assert (foldIdx < PT_IDX_W'(PT_COUNT) || foldOut); // R7
  end
endmodule

bind ptsum_cell ptsum_cell_chk u_chk (
  .routeCfg(routeCfg), .xorMode(xorMode), .xorIdx(xorIdx), .foldIdx(foldIdx),
  .casIn(casIn), .casOut(casOut), .cellOut(cellOut), .ctrlOut(ctrlOut),
  .foldOut(foldOut)
);

// File: tb/ptsum_cell_bench.sv
`timescale 1ns/1ps
module ptsum_cell_bench;
  localparam int NI = 8;
  localparam int NP = 5;
  localparam int CW = NP * NI * 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [NI-1:0] sigIn;
  logic [CW-1:0] termCfg;
  logic [NP-1:0] routeCfg;
  logic [1:0]    xorMode;
  logic [2:0]    xorIdx, foldIdx;
  logic          casIn, casOut, cellOut, foldOut;
  logic [NP-1:0] ctrlOut;

  int checkCnt = 0;
  int failCnt = 0;

  ptsum_cell #(.NUM_IN(NI)) u_ptsum_cell (
    .sigIn(sigIn), .termCfg(termCfg), .routeCfg(routeCfg), .xorMode(xorMode),
    .xorIdx(xorIdx), .foldIdx(foldIdx), .casIn(casIn), .casOut(casOut),
    .cellOut(cellOut), .ctrlOut(ctrlOut), .foldOut(foldOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model: literal codes 1=true, 2=complement, 3=both, 0=ignore
  function automatic int refTerm(int t);
    int v = 1;
    for (int i = 0; i < NI; i++) begin
      int code = int'(termCfg[(t*NI+i)*2 +: 2]);
      if (code == 3) v = 0;
      else if (code == 1 && sigIn[i] == 1'b0) v = 0;
      else if (code == 2 && sigIn[i] == 1'b1) v = 0;
    end
    return v;
  endfunction

  task automatic compareAll();
    int sum = casIn ? 1 : 0;
    int ctl = 0;
    int opnd = 0;
    int fold = 1;
    int expCell;
    for (int t = 0; t < NP; t++) begin
      int v = refTerm(t);
      if (routeCfg[t]) ctl += v << t;
      else if (v == 1) sum = 1;
    end
    if (xorMode == 2'b01) opnd = 1;
    if (xorMode == 2'b10 && xorIdx < 3'd5) opnd = refTerm(int'(xorIdx));
    if (foldIdx < 3'd5) fold = 1 - refTerm(int'(foldIdx));
    expCell = sum ^ opnd;
    chk(casIn ? "R8 chain" : "R4 sum", int'(casOut), sum);
    chk("R3 control routing", int'(ctrlOut), ctl);
    chk(xorMode[1] ? "R6 xor operand" : "R5 polarity", int'(cellOut), expCell);
    chk("R7 foldback", int'(foldOut), fold);
  endtask

  task automatic setLit(int t, int i, logic [1:0] code);
    termCfg[(t*NI+i)*2 +: 2] = code;
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog actual=timeout expected=done");
    failCnt++; checkCnt++;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    sigIn = '0; termCfg = '0; routeCfg = '0; xorMode = 2'b00;
    xorIdx = 3'd0; foldIdx = 3'd0; casIn = 1'b0;
    @(posedge clk); #1;
    // R2: all-empty terms evaluate to 1, so the sum is high and fold is 0
    @(negedge clk);
    chk("R2 empty term sum", int'(casOut), 1);
    chk("R2 empty term fold", int'(foldOut), 0);
    routeCfg = 5'b11111;
    #1;
    chk("R2 empty terms on control", int'(ctrlOut), 31);
    chk("R3 all routed away", int'(casOut), 0);
    // R1: term 0 = s0 & ~s1; term 1 uses both-literal code
    setLit(0, 0, 2'b01); setLit(0, 1, 2'b10); setLit(1, 2, 2'b11);
    sigIn = 8'b0000_0001;
    #1;
    chk("R1 true and complement literal", int'(ctrlOut[0]), 1);
    chk("R1 both literals force zero", int'(ctrlOut[1]), 0);
    sigIn = 8'b0000_0011;
    #1;
    chk("R1 complement literal blocks", int'(ctrlOut[0]), 0);
    // R8: cascade in high with every local term blocked
    routeCfg = 5'b11111; casIn = 1'b1;
    #1;
    chk("R8 chain passes", int'(casOut), 1);
    casIn = 1'b0;
    // R6: out-of-range indices
    xorMode = 2'b10; xorIdx = 3'd7; foldIdx = 3'd6; routeCfg = 5'b00000;
    #1;
    chk("R6 out-of-range xor index", int'(cellOut), int'(casOut));
    chk("R7 out-of-range fold index", int'(foldOut), 1);
    @(posedge clk); #1;
    // directed mode sweep then random patterns
    for (int m = 0; m < 4; m++) begin
      xorMode = 2'(m);
      for (int k = 0; k < 8; k++) begin
        sigIn = 8'(k * 37);
        xorIdx = 3'(k); foldIdx = 3'(7 - k); routeCfg = 5'(k * 5);
        casIn = 1'b0;
        step();
      end
    end
    for (int n = 0; n < 600; n++) begin
      for (int t = 0; t < NP; t++)
        for (int i = 0; i < NI; i++) begin
          int r = int'($urandom_range(0, 11));
          setLit(t, i, r < 8 ? 2'b00 : r < 10 ? 2'b01 : r < 11 ? 2'b10 : 2'b11);
        end
      sigIn = 8'($urandom);
      routeCfg = 5'($urandom);
      xorMode = 2'($urandom);
      xorIdx = 3'($urandom);
      foldIdx = 3'($urandom);
      casIn = ($urandom_range(0, 7) == 0);
      step();
    end
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule